// File: doc/BRIEF.md
# Integrating Bus Overvoltage Trip

This block decides when a rising DC bus voltage is a genuine overvoltage and latches a fault that shuts off the power stage. It receives one bus voltage sample per PWM period with a valid strobe. It compares each sample against a limit that software can change. In the default mode it adds up how far the bus goes over the limit. The trip time therefore shrinks as the overshoot grows: a gross overshoot trips on one sample, while a slight overshoot that noise may cause must persist for many periods.

A second mode keeps the older behaviour. It counts consecutive over-limit samples and trips on a fixed run length, and any single good sample starts the count again. A fixed hardware ceiling can be built in with a parameter. When built in, it trips on any one sample above it, in either mode and at any user limit. The fault is sticky and holds the gate-disable output active until software clears it. The running accumulator value is brought out for debug.

The control is a two-state machine. In ARMED the block takes samples and updates its evidence. The TRIP transition goes from ARMED to TRIPPED when the integrator, the streak counter or the ceiling fires on a taken sample. In TRIPPED all samples are ignored. The CLEAR transition goes from TRIPPED back to ARMED on a clear pulse and wipes the evidence. A clear pulse while ARMED is a self-loop that also wipes the evidence.

Top module: `ovp_guard`

## Requirements
- R1: After reset, `fault` and `gate_off` are 0 and `acc_mv` is 0.
- R2: In integrating mode (`mode_legacy`=0), a taken sample with `smp_mv` > `lim_mv` adds (`smp_mv` − `lim_mv`) to the accumulator. All voltages are unsigned millivolts.
- R3: In integrating mode, a taken sample with `smp_mv` <= `lim_mv` lowers the accumulator by 1000 mV, stopping at 0.
- R4: In integrating mode, when an over-limit sample brings the accumulator to `lim_mv`/20 (integer division) or higher, the fault trips and the accumulator is set to exactly `lim_mv`/20. A single sample at least `lim_mv`/20 above the limit therefore trips on that sample.
- R5: In legacy mode (`mode_legacy`=1), the fault trips on the 8th consecutive over-limit taken sample. A sample at or below the limit restarts the count. The accumulator holds its value in this mode.
- R6: Any taken sample with `smp_mv` above the hardware ceiling (parameter, default 60000 mV) trips the fault, in either mode.
- R7: Once tripped, `fault` and `gate_off` stay 1 and samples have no effect until `fault_clr` is high at a clock edge. That edge drops both outputs and zeroes the accumulator and the streak count. A clear beats a sample taken in the same cycle.
- R8: `fault` and `gate_off` rise on the same clock edge that takes the triggering sample. The trip has one cycle of latency.
- R9: While `smp_vld` is 0, the sample value is ignored and `acc_mv` and `fault` hold.
- R10: A new `lim_mv` applies from the next taken sample. The accumulator is not rescaled, so a lower limit whose trip level is at or under the stored accumulator trips on the next over-limit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe, one per PWM period |
| smp_mv | input | 16 | Bus voltage sample in mV |
| lim_mv | input | 16 | Programmable overvoltage limit in mV |
| mode_legacy | input | 1 | 0 = integrating, 1 = consecutive-count |
| fault_clr | input | 1 | Clears the latched fault |
| fault | output | 1 | Latched overvoltage fault |
| gate_off | output | 1 | Power stage disable, active high |
| acc_mv | output | 16 | Accumulator value for debug |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the sticky fault and the clear that resets it, holding state while the strobe is low, the 1000 mV bleed step, the ceiling trip, and that a fault only rises after a taken sample. The bench scenarios are needed for the rest, because they depend on running totals. These are the exact number of marginal samples before a trip, the clamp at `lim_mv`/20, the legacy run of eight and its restart after a good sample, and the effect of changing the limit with a stored accumulator.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRIPPED = 1'b1
    } ovp_state_e;

    localparam int MV_W = 16;

    typedef logic [MV_W-1:0] mv_t;

endpackage

// File: rtl/ovp_integ.sv
// Excess-voltage integrator: combinational next value and trip decision.
module ovp_integ #(
    parameter int W       = 16,
    parameter int DECAY   = 1000,
    parameter int TRIPDIV = 20
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] lim,
    output logic [W-1:0] acc_nx,
    output logic         hit
);
    localparam logic [W-1:0] DEC = W'(DECAY);

    logic         over;
    logic [W-1:0] excess;
    logic [W:0]   sum;
    logic [W-1:0] thr;

    always_comb begin
        over   = smp > lim;
        excess = over ? (smp - lim) : '0;
        sum    = {1'b0, acc} + {1'b0, excess};
        thr    = lim / W'(TRIPDIV);
        hit    = over && (sum >= {1'b0, thr});
        if (!over)
            acc_nx = (acc > DEC) ? (acc - DEC) : '0;
        else if (hit)
            acc_nx = thr;
        else
            acc_nx = sum[W-1:0];
    end
endmodule

// File: rtl/ovp_streak.sv
// Consecutive over-limit sample counter (legacy behaviour).
module ovp_streak #(
    parameter int RUN = 8,
    parameter int CW  = $clog2(RUN + 1)
) (
    input  logic          over,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx,
    output logic          hit
);
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);

    always_comb begin
        hit = over && (cnt == LAST);
        if (!over)
            cnt_nx = '0;
        else if (hit)
            cnt_nx = cnt;
        else
            cnt_nx = cnt + CW'(1);
    end
endmodule

// File: rtl/ovp_ceiling.sv
// Fixed hardware ceiling comparator; built only when enabled.
module ovp_ceiling #(
    parameter int W       = 16,
    parameter bit USE     = 1'b1,
    parameter int CEIL_MV = 60000
) (
    input  logic [W-1:0] smp,
    output logic         hit
);
    generate
        if (USE) begin : g_on
            assign hit = smp > W'(CEIL_MV);
        end else begin : g_off
            logic unused_smp;
            assign unused_smp = ^smp;
            assign hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ovp_guard.sv
module ovp_guard
    import ovp_pkg::*;
#(
    parameter int LEG_RUN  = 8,
    parameter int DECAY_MV = 1000,
    parameter int TRIP_DIV = 20,
    parameter bit USE_CEIL = 1'b1,
    parameter int CEIL_MV  = 60000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_vld,
    input  logic [15:0] smp_mv,
    input  logic [15:0] lim_mv,
    input  logic        mode_legacy,
    input  logic        fault_clr,
    output logic        fault,
    output logic        gate_off,
    output logic [15:0] acc_mv
);
    localparam int CW = $clog2(LEG_RUN + 1);

    ovp_state_e    st_q, st_nx;
    mv_t           acc_q, acc_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic          integ_hit, streak_hit, ceil_hit;
    logic          take, trip;

    ovp_integ #(.W(MV_W), .DECAY(DECAY_MV), .TRIPDIV(TRIP_DIV)) u_integ (
        .acc    (acc_q),
        .smp    (smp_mv),
        .lim    (lim_mv),
        .acc_nx (acc_nx),
        .hit    (integ_hit)
    );

    ovp_streak #(.RUN(LEG_RUN), .CW(CW)) u_streak (
        .over   (smp_mv > lim_mv),
        .cnt    (cnt_q),
        .cnt_nx (cnt_nx),
        .hit    (streak_hit)
    );

    ovp_ceiling #(.W(MV_W), .USE(USE_CEIL), .CEIL_MV(CEIL_MV)) u_ceil (
        .smp (smp_mv),
        .hit (ceil_hit)
    );

    always_comb begin
        take = smp_vld && !fault_clr && (st_q == ST_ARMED);
        trip = take && (ceil_hit || (mode_legacy ? streak_hit : integ_hit));
    end

    // Next-state logic: TRIP and CLEAR transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_ARMED:   if (trip)      st_nx = ST_TRIPPED;
            ST_TRIPPED: if (fault_clr) st_nx = ST_ARMED;
            default:                   st_nx = ST_ARMED;
        endcase
    end

    // State register plus evidence registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ARMED;
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q <= st_nx;
            if (fault_clr) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (take) begin
                if (mode_legacy) cnt_q <= cnt_nx;
                else             acc_q <= acc_nx;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault    <= 1'b0;
            gate_off <= 1'b0;
        end else begin
            fault    <= (st_nx == ST_TRIPPED);
            gate_off <= (st_nx == ST_TRIPPED);
        end
    end

    assign acc_mv = acc_q;
endmodule

// File: rtl/ovp_guard_chk.sv
module ovp_guard_chk #(
    parameter int DECAY_MV = 1000,
    parameter bit USE_CEIL = 1'b1,
    parameter int CEIL_MV  = 60000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_vld,
    input logic [15:0] smp_mv,
    input logic [15:0] lim_mv,
    input logic        mode_legacy,
    input logic        fault_clr,
    input logic        fault,
    input logic        gate_off,
    input logic [15:0] acc_mv
);
    AST_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off == fault); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !fault_clr |=> fault); // R7

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault && acc_mv == 16'd0); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && !fault_clr |=> $stable(acc_mv) && $stable(fault)); // R9

    AST_BLEED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !fault_clr && !fault && !mode_legacy && smp_mv <= lim_mv
        |=> acc_mv == (($past(acc_mv) > 16'(DECAY_MV)) ? $past(acc_mv) - 16'(DECAY_MV) : 16'd0)); // R3

    AST_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(smp_vld) && !$past(fault_clr)); // R8

    AST_CEIL_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        USE_CEIL && smp_vld && !fault_clr && smp_mv > 16'(CEIL_MV) |=> fault); // R6
endmodule

bind ovp_guard ovp_guard_chk #(.DECAY_MV(DECAY_MV), .USE_CEIL(USE_CEIL), .CEIL_MV(CEIL_MV)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mv(smp_mv), .lim_mv(lim_mv),
    .mode_legacy(mode_legacy), .fault_clr(fault_clr), .fault(fault),
    .gate_off(gate_off), .acc_mv(acc_mv)
);

// File: tb/sim_ovp_guard.sv
`timescale 1ns/1ps
module sim_ovp_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_mv = '0;
    logic [15:0] lim_mv = 16'd57000;
    logic        mode_legacy = 1'b0;
    logic        fault_clr = 1'b0;
    logic        fault, gate_off;
    logic [15:0] acc_mv;

    always #10 clk = ~clk; // 50 MHz

    ovp_guard u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mv(smp_mv),
        .lim_mv(lim_mv), .mode_legacy(mode_legacy), .fault_clr(fault_clr),
        .fault(fault), .gate_off(gate_off), .acc_mv(acc_mv)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // Reference model state
    bit         m_fault = 0;
    int         m_acc   = 0;
    int         m_cnt   = 0;

    // Scoreboard queues
    int    q_due[$];
    bit    q_f[$];
    int    q_a[$];
    string q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compares once the design has registered the step
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            void'(q_due.pop_front());
            begin
                bit    ef;
                int    ea;
                string t;
                ef = q_f.pop_front();
                ea = q_a.pop_front();
                t  = q_tag.pop_front();
                check(t, int'(fault), int'(ef), "fault");
                check(t, int'(gate_off), int'(ef), "gate_off");
                check(t, int'(acc_mv), ea, "acc_mv");
            end
        end
    end

    // Driver: one step per clock, model updated from the requirements
    task automatic step(input bit v, input int s, input int l, input bit leg,
                        input bit clr, input string tag);
        bit over, tk, hit;
        int thr, sum;
        @(posedge clk);
        #2;
        smp_vld = v; smp_mv = 16'(s); lim_mv = 16'(l);
        mode_legacy = leg; fault_clr = clr;
        over = s > l;
        tk   = v && !clr && !m_fault;
        thr  = l / 20;
        if (clr) begin
            m_fault = 0; m_acc = 0; m_cnt = 0;
        end else if (tk) begin
            hit = (s > 60000);
            if (leg) begin
                if (over) begin
                    if (m_cnt == 7) hit = 1; else m_cnt++;
                end else m_cnt = 0;
            end else begin
                if (over) begin
                    sum = m_acc + (s - l);
                    if (sum >= thr) begin hit = 1; m_acc = thr; end
                    else m_acc = sum;
                end else m_acc = (m_acc > 1000) ? m_acc - 1000 : 0;
            end
            if (hit) m_fault = 1;
        end
        q_due.push_back(cyc + 1);
        q_f.push_back(m_fault);
        q_a.push_back(m_acc);
        q_tag.push_back(tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #35;
        check("R1", int'(fault), 0, "fault in reset");
        check("R1", int'(acc_mv), 0, "acc in reset");
        rst_n = 1'b1;
        #15;
        check("R1", int'(gate_off), 0, "gate_off after reset");

        // R4: one sample exactly lim/20 above trips at once and clamps
        step(1, 59850, 57000, 0, 0, "R4_single");
        step(1, 59900, 57000, 0, 0, "R7_ignored_while_tripped");
        step(0, 0, 57000, 0, 0, "R7_sticky");
        step(0, 0, 57000, 0, 1, "R7_clear");

        // R2: marginal overshoot accumulates for 28 samples, trips on 29th
        for (int i = 0; i < 28; i++) step(1, 57100, 57000, 0, 0, "R2_accumulate");
        step(1, 57100, 57000, 0, 0, "R4_marginal_trip");
        step(1, 57000, 57000, 0, 1, "R7_clear_beats_sample");

        // R3: bleed down and saturate at zero
        step(1, 58500, 57000, 0, 0, "R2_excess");
        step(1, 57000, 57000, 0, 0, "R3_bleed");
        step(1, 50000, 57000, 0, 0, "R3_floor");

        // R9: strobe low ignores an extreme sample
        step(1, 58000, 57000, 0, 0, "R2_build");
        step(0, 65000, 57000, 0, 0, "R9_strobe_low");
        step(0, 65000, 57000, 0, 0, "R9_hold");

        // R10: lower limit, stored acc 1000 exceeds new trip level 500
        step(1, 10001, 10000, 0, 0, "R10_new_limit");
        step(0, 0, 10000, 0, 1, "R7_clear2");

        // R5: legacy run broken by a good sample, then eight in a row
        for (int i = 0; i < 7; i++) step(1, 58000, 57000, 1, 0, "R5_run");
        step(1, 56000, 57000, 1, 0, "R5_restart");
        for (int i = 0; i < 7; i++) step(1, 58000, 57000, 1, 0, "R5_rerun");
        step(1, 58000, 57000, 1, 0, "R5_eighth");
        step(0, 0, 57000, 1, 1, "R7_clear3");

        // R6: ceiling in legacy mode with a high user limit
        step(1, 61000, 65000, 1, 0, "R6_ceiling_legacy");
        step(0, 0, 65000, 1, 1, "R7_clear4");
        // R6: ceiling in integrating mode, excess below trip level
        step(1, 60001, 60000, 0, 0, "R6_ceiling_integ");
        step(0, 0, 60000, 0, 1, "R7_clear5");

        // R8: trip visible exactly one edge later (checked by scoreboard timing)
        step(1, 62000, 57000, 0, 0, "R8_latency");
        step(0, 0, 57000, 0, 0, "R8_after");
        step(0, 0, 57000, 0, 0, "R8_flush");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule